// File: doc/BRIEF.md
# External Oscillator Failure Monitor

This block watches an external oscillator running in any of the external modes (low-power crystal, standard crystal or a driven external clock) and declares it failed when it stops toggling. A slow reference, built by dividing a low-frequency internal oscillator of roughly 32 kHz by a parameterised ratio (64 by default), defines the checking windows. Every rising edge of the reference clears a detector latch. Every falling edge of the external clock sets it again. When the reference falls, the latch is inspected. If no external falling edge has arrived during the whole high half of the reference, a failure is declared.

Both monitored clocks are brought into a fast free-running monitor clock domain through synchroniser chains, and all edges are found there. On a failure the block moves its clock-select output to the internal source and sets a sticky fault flag. Software clears the flag with an explicit clear input. The clock-select output stays on the internal source until the next reset. An interrupt request is raised while the flag and its enable are both high. Checking runs only while the configuration enable is high and the start-up timer has reported expiry. Recovery or restart of the external oscillator is not handled here.

Top module: `fscm_monitor`

## Requirements
- R1: After reset, the fault flag is 0, the interrupt request is 0 and the clock-select output is 0, meaning the external source.
- R2: One checking window lasts DIV/2 rising edges of the low-frequency clock. With the external clock stopped and checking enabled from an idle state, the fault flag rises after DIV/2 low-frequency periods, plus the synchroniser and register latency.
- R3: If the external clock produces at least one falling edge within every DIV/2 low-frequency periods, no fault is declared. This covers a period equal to 100/128 of the window.
- R4: If the external clock stops, whether held high or held low, or if its period is longer than 1.5 reference periods, the fault flag is set within two reference periods plus latency.
- R5: No fault is declared while the monitor enable is 0 or the start-up-expired input is 0, even when the external clock is stopped.
- R6: The clock-select output changes to 1 (internal source) in the same cycle that the fault flag first rises.
- R7: Once at 1, the clock-select output stays at 1 until reset. Clearing the flag or restarting the external clock does not return it to 0.
- R8: The fault flag stays at 1 until the clear input is pulsed. A clear takes effect only in a cycle with no new failure; a new failure takes priority over a clear.
- R9: The interrupt request is 1 exactly when the fault flag is 1 and the interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_clk | input | 1 | External oscillator under watch (asynchronous) |
| lf_clk | input | 1 | Low-frequency internal oscillator (asynchronous) |
| mon_en | input | 1 | Configuration enable for the monitor |
| ost_done | input | 1 | Oscillator start-up timer has expired |
| irq_en | input | 1 | Interrupt enable for the fault flag |
| flag_clr | input | 1 | Single-cycle clear of the fault flag |
| fault_flag | output | 1 | Sticky oscillator-failure flag |
| irq | output | 1 | Interrupt request |
| clk_sel_int | output | 1 | 1 selects the internal clock source, 0 the external one |

## Verification
The assertions assume that both monitored clocks toggle much more slowly than the monitor clock, so that every edge lasts several monitor cycles and the synchronisers see it. They also assume that the control inputs are synchronous to the monitor clock. The stimulus drives every input on the falling edge of the monitor clock. It keeps each low-frequency half period at two monitor cycles and each external half period at two cycles or more. Random external periods are drawn only from ranges that lie clearly inside or clearly outside the checking window, so that each expected outcome follows from the requirements alone.

// File: rtl/fscm_pkg.sv
package fscm_pkg;
  localparam int unsigned FSCM_DIV_DEFAULT  = 64;
  localparam int unsigned FSCM_SYNC_DEFAULT = 2;

  typedef enum logic {
    CLK_SRC_EXT = 1'b0,
    CLK_SRC_INT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/fscm_edge_det.sv
module fscm_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  always_comb begin
    rise = sync_q[STAGES-1] & ~prev_q;
    fall = ~sync_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/fscm_sample_div.sv
module fscm_sample_div #(
  parameter int unsigned DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic lf_rise,
  output logic win_open,
  output logic win_close
);
  localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int unsigned HALF = DIV / 2;
  localparam logic [CW-1:0] LAST     = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF_M1  = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en    = active & lf_rise;
    win_open  = cnt_en & (cnt_q == LAST);
    win_close = cnt_en & (cnt_q == HALF_M1);
    cnt_d     = cnt_q;
    if (!active)          cnt_d = '0;
    else if (cnt_en)      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fscm_fail_latch.sv
module fscm_fail_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ext_fall,
  input  logic win_open,
  input  logic win_close,
  output logic fail_evt
);
  logic seen_q, seen_d;

  always_comb begin
    seen_d = seen_q;
    if (ext_fall)                 seen_d = 1'b1;
    else if (!active || win_open) seen_d = 1'b0;
    fail_evt = active & win_close & ~seen_q & ~ext_fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end
endmodule

// File: rtl/fscm_monitor.sv
module fscm_monitor
  import fscm_pkg::*;
#(
  parameter int unsigned DIV         = FSCM_DIV_DEFAULT,
  parameter int unsigned SYNC_STAGES = FSCM_SYNC_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic lf_clk,
  input  logic mon_en,
  input  logic ost_done,
  input  logic irq_en,
  input  logic flag_clr,
  output logic fault_flag,
  output logic irq,
  output logic clk_sel_int
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       ext_rise_unused, ext_fall;
  logic       lf_rise, lf_fall_unused;
  logic       active, win_open, win_close, fail_evt;
  logic       flag_q, flag_d;
  clk_src_e   sel_q, sel_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  fscm_edge_det #(.STAGES(SYNC_STAGES)) u_ext_edge (
    .clk(clk), .rst_n(rst_int_n), .async_in(ext_clk),
    .rise(ext_rise_unused), .fall(ext_fall)
  );

  fscm_edge_det #(.STAGES(SYNC_STAGES)) u_lf_edge (
    .clk(clk), .rst_n(rst_int_n), .async_in(lf_clk),
    .rise(lf_rise), .fall(lf_fall_unused)
  );

  assign active = mon_en & ost_done;

  fscm_sample_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_int_n), .active(active), .lf_rise(lf_rise),
    .win_open(win_open), .win_close(win_close)
  );

  fscm_fail_latch u_latch (
    .clk(clk), .rst_n(rst_int_n), .active(active), .ext_fall(ext_fall),
    .win_open(win_open), .win_close(win_close), .fail_evt(fail_evt)
  );

  always_comb begin
    flag_d = flag_q;
    sel_d  = sel_q;
    if (fail_evt) begin
      flag_d = 1'b1;
      sel_d  = CLK_SRC_INT;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      flag_q <= 1'b0;
      sel_q  <= CLK_SRC_EXT;
    end else begin
      flag_q <= flag_d;
      sel_q  <= sel_d;
    end
  end

  assign fault_flag  = flag_q;
  assign clk_sel_int = (sel_q == CLK_SRC_INT);
  assign irq         = flag_q & irq_en;
endmodule

// File: rtl/fscm_monitor_chk.sv
module fscm_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic mon_en,
  input logic ost_done,
  input logic irq_en,
  input logic flag_clr,
  input logic fault_flag,
  input logic irq,
  input logic clk_sel_int
);
  assert_idle_no_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_flag && !(mon_en && ost_done)) |=> !fault_flag);

  assert_flag_brings_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> clk_sel_int);

  assert_sel_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel_int |=> clk_sel_int);

  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !flag_clr) |=> fault_flag);

  assert_clear_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(mon_en && ost_done)) |=> !fault_flag);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fault_flag && irq_en));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && irq_en) |-> irq);
endmodule

bind fscm_monitor fscm_monitor_chk i_fscm_monitor_chk (
  .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .ost_done(ost_done),
  .irq_en(irq_en), .flag_clr(flag_clr), .fault_flag(fault_flag),
  .irq(irq), .clk_sel_int(clk_sel_int)
);

// File: tb/test_fscm_monitor.sv
`timescale 1ns/1ps
module test_fscm_monitor;
  logic clk = 1'b0;
  logic rst_n, ext_clk, lf_clk, mon_en, ost_done, irq_en, flag_clr;
  logic fault_flag, irq, clk_sel_int;

  int n_checks = 0;
  int n_fail   = 0;
  int ext_half = 0;
  int ext_cnt  = 0;
  int lf_cnt   = 0;

  localparam int LF_HALF = 2;

  always #2 clk = ~clk;

  fscm_monitor i_fscm_monitor (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .lf_clk(lf_clk),
    .mon_en(mon_en), .ost_done(ost_done), .irq_en(irq_en),
    .flag_clr(flag_clr), .fault_flag(fault_flag), .irq(irq),
    .clk_sel_int(clk_sel_int)
  );

  initial begin
    lf_clk = 1'b0;
    forever begin
      @(negedge clk);
      if (lf_cnt >= LF_HALF - 1) begin lf_clk = ~lf_clk; lf_cnt = 0; end
      else lf_cnt++;
    end
  end

  initial begin
    ext_clk = 1'b0;
    forever begin
      @(negedge clk);
      if (ext_half != 0) begin
        if (ext_cnt >= ext_half - 1) begin ext_clk = ~ext_clk; ext_cnt = 0; end
        else ext_cnt++;
      end
    end
  end

  function automatic bit exp_irq(input logic flag, input logic en);
    return flag && en;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mon_en = 1'b1; ost_done = 1'b1; irq_en = 1'b0; flag_clr = 1'b0;
    ext_half = 5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic stop_ext(input logic lvl);
    @(negedge clk);
    ext_half = 0;
    ext_clk  = lvl;
  endtask

  task automatic run_quiet(input int cycles, input string req);
    int raised = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (fault_flag) raised = 1;
    end
    check(raised == 0, req, raised, 0);
  endtask

  task automatic wait_fault(input int max_cyc, output int took);
    took = -1;
    for (int i = 1; i <= max_cyc; i++) begin
      @(negedge clk);
      if (fault_flag) begin took = i; break; end
    end
  endtask

  initial begin
    int took;
    int hv;
    void'($urandom(32'd2024));
    rst_n = 1'b0; mon_en = 1'b0; ost_done = 1'b0; irq_en = 1'b0; flag_clr = 1'b0;

    do_reset();
    check(fault_flag == 1'b0, "R1 flag", fault_flag, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(clk_sel_int == 1'b0, "R1 sel", clk_sel_int, 0);

    run_quiet(2000, "R3 healthy half=5");

    irq_en = 1'b1;
    stop_ext(1'b1);
    wait_fault(700, took);
    check(took > 0, "R4 stuck high", took, 1);
    check(clk_sel_int == 1'b1, "R6 sel with flag", clk_sel_int, 1);
    check(irq == exp_irq(fault_flag, irq_en), "R9 irq on", irq, 1);
    irq_en = 1'b0;
    @(negedge clk);
    check(irq == exp_irq(fault_flag, irq_en), "R9 irq masked", irq, 0);
    repeat (50) @(negedge clk);
    check(fault_flag == 1'b1, "R8 flag sticky", fault_flag, 1);
    mon_en = 1'b0; flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    @(negedge clk);
    check(fault_flag == 1'b0, "R8 clear", fault_flag, 0);
    check(clk_sel_int == 1'b1, "R7 sel after clear", clk_sel_int, 1);
    ext_half = 5; mon_en = 1'b1;
    repeat (500) @(negedge clk);
    check(clk_sel_int == 1'b1, "R7 sel after restart", clk_sel_int, 1);

    do_reset();
    mon_en = 1'b0;
    stop_ext(1'b0);
    run_quiet(1000, "R5 monitor disabled");
    mon_en = 1'b1; ost_done = 1'b0;
    run_quiet(1000, "R5 start-up not expired");
    ost_done = 1'b1;
    wait_fault(400, took);
    check(took >= 120 && took <= 145, "R2 window length", took, 132);
    check(took > 0, "R4 stuck low", took, 1);

    do_reset();
    ext_half = 50;
    run_quiet(3000, "R3 period 100 boundary");
    ext_half = 400;
    wait_fault(2000, took);
    check(took > 0, "R4 slow period 800", took, 1);

    for (int k = 0; k < 6; k++) begin
      do_reset();
      hv = 2 + int'($urandom_range(47));
      ext_half = hv;
      run_quiet(1500, "R3 random healthy");
      stop_ext(logic'($urandom_range(1)));
      wait_fault(700, took);
      check(took > 0, "R4 random stop", took, 1);
      check(clk_sel_int == 1'b1, "R6 random sel", clk_sel_int, 1);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule